// File: doc/BRIEF.md
# Memory Bank Chip-Select Decoder

This block is the glue between a 16-bit data bus processor with a 20-bit multiplexed address/data bus and a 1 MB memory built from eight 128 KB chips. The chips form four pairs: three SRAM pairs and one EEPROM pair. Each pair has an even chip, which carries the low data byte, and an odd chip, which carries the high data byte. The block captures the address and the high-byte enable when the address strobe falls. The two top address bits then pick one pair. The next seventeen bits go to every chip as the in-chip word address. Address bit 0 and the high-byte enable pick the byte lanes inside the selected pair.

The block drives active-low enables for each chip, and active-low output-enable and write-enable strobes. Chip enables are only asserted during a memory read or write. A write aimed at the EEPROM pair never reaches the chips. Instead it raises a write-protect flag for one cycle.

All state is clocked by one clock with a synchronous active-high reset. The strobe-driven outputs follow the current strobes combinationally from the latched address.

Top module: `mem_bank_decode`

## Requirements
- R1: After reset, every chip enable, `oe_n` and `we_n` are high, `wp_violation` is low and `word_addr` is 0.
- R2: The block latches `bus_ad` and `hi_byte_en_n` on the first clock edge that samples `addr_strobe` low after it was sampled high. `word_addr` and the chip enables then ignore later changes on `bus_ad` and `hi_byte_en_n` until the next such edge.
- R3: `word_addr` equals bits 17 down to 1 of the latched address.
- R4: Latched bits 19:18 select pair index 0 to 3. Bit i of `ce_even_n` and `ce_odd_n` belongs to pair i. Pair 3 is the EEPROM pair and pairs 0 to 2 are SRAM. At most one pair has any enable low.
- R5: In the selected pair, the even chip is enabled when latched address bit 0 is 0. The odd chip is enabled when latched `hi_byte_en_n` is 0. When both are 0, both chips are enabled. Bit 0 = 1 together with `hi_byte_en_n` = 1 enables neither chip.
- R6: Chip enables can only be low while `mem_io` = 1 (memory cycle) and `rd_n` or `wr_n` is low. Otherwise all of them are high.
- R7: `oe_n` is low exactly when `mem_io` = 1 and `rd_n` = 0. `we_n` is low exactly when `mem_io` = 1, `wr_n` = 0 and the selected pair is not pair 3.
- R8: `wp_violation` is high for exactly one clock. It rises on the edge that first samples `wr_n` low in a memory cycle whose selected pair is pair 3. It stays low for writes to SRAM and for I/O cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_strobe | input | 1 | Address strobe; the address is captured when it falls |
| bus_ad | input | 20 | Multiplexed address/data bus |
| hi_byte_en_n | input | 1 | Active-low high-byte enable from the processor |
| mem_io | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| word_addr | output | 17 | In-chip word address to all chips |
| ce_even_n | output | 4 | Active-low enables of the even chips, one per pair |
| ce_odd_n | output | 4 | Active-low enables of the odd chips, one per pair |
| oe_n | output | 1 | Active-low output enable to the chips |
| we_n | output | 1 | Active-low write enable to the chips |
| wp_violation | output | 1 | One-cycle flag for a write to the EEPROM pair |

## Verification
Some properties are checked on every clock by assertions:
- at most one pair is enabled;
- nothing is enabled outside an active memory strobe;
- the lane-idle combination enables no chip;
- the write enable never reaches the EEPROM pair;
- the write-protect flag lasts one cycle;
- the word address holds while the strobe stays low.

Only the bench scenarios can show that the right pair and lanes are chosen for particular addresses, including the boundaries at 3FFFE and 40000 and the top of memory. The scenarios also show that data-phase values on the bus do not disturb the latched address, and that the flag appears on the right edge and is absent for SRAM writes and I/O cycles.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
    localparam int ADDR_W     = 20;
    localparam int PAIR_SEL_W = 2;
    localparam int NUM_PAIRS  = 1 << PAIR_SEL_W;
    localparam int WORD_W     = ADDR_W - PAIR_SEL_W - 1;
    localparam int ROM_PAIR   = NUM_PAIRS - 1;

    typedef struct packed {
        logic even;
        logic odd;
    } lane_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              hi_n;
    } bus_latch_t;

    function automatic lane_t lanes_of(input logic a0, input logic hi_n);
        lane_t l;
        l.even = ~a0;
        l.odd  = ~hi_n;
        return l;
    endfunction

    function automatic logic [PAIR_SEL_W-1:0] pair_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: PAIR_SEL_W];
    endfunction

    function automatic logic [WORD_W-1:0] word_of(input logic [ADDR_W-1:0] a);
        return a[WORD_W:1];
    endfunction
endpackage

// File: rtl/mbd_addr_latch.sv
module mbd_addr_latch
    import mbd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       addr_strobe,
    input  logic [ADDR_W-1:0] bus_ad,
    input  logic       hi_byte_en_n,
    output bus_latch_t latched
);
    logic strobe_q;
    logic capture;

    assign capture = strobe_q & ~addr_strobe;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q     <= 1'b0;
            latched.addr <= '0;
            latched.hi_n <= 1'b1;
        end else begin
            strobe_q <= addr_strobe;
            if (capture) begin
                latched.addr <= bus_ad;
                latched.hi_n <= hi_byte_en_n;
            end
        end
    end

    // R2: while the strobe stays low the captured value must not move
    assert_latch_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!addr_strobe && !strobe_q) |=> $stable(latched));
endmodule

// File: rtl/mbd_pair_decode.sv
module mbd_pair_decode
    import mbd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_latch_t latched,
    input  logic       access,
    output logic [NUM_PAIRS-1:0] ce_even_n,
    output logic [NUM_PAIRS-1:0] ce_odd_n,
    output logic [WORD_W-1:0]    word_addr,
    output logic       rom_hit
);
    lane_t                 lanes;
    logic [PAIR_SEL_W-1:0] pair;

    assign lanes     = lanes_of(latched.addr[0], latched.hi_n);
    assign pair      = pair_of(latched.addr);
    assign word_addr = word_of(latched.addr);
    assign rom_hit   = (pair == PAIR_SEL_W'(ROM_PAIR));

    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
        logic hit;
        assign hit          = access && (pair == PAIR_SEL_W'(i));
        assign ce_even_n[i] = ~(hit & lanes.even);
        assign ce_odd_n[i]  = ~(hit & lanes.odd);
    end

    // R4: no two pairs enabled together
    assert_one_pair_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~(ce_even_n & ce_odd_n)));
    // R5: odd address with high byte disabled touches no chip
    assert_lane_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (latched.addr[0] && latched.hi_n) |-> (&ce_even_n && &ce_odd_n));
endmodule

// File: rtl/mbd_strobe_ctrl.sv
module mbd_strobe_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic mem_io,
    input  logic rd_n,
    input  logic wr_n,
    input  logic rom_hit,
    output logic access,
    output logic oe_n,
    output logic we_n,
    output logic wp_violation
);
    logic rd_act;
    logic wr_act;
    logic wr_q;

    assign rd_act = mem_io & ~rd_n;
    assign wr_act = mem_io & ~wr_n;
    assign access = rd_act | wr_act;
    assign oe_n   = ~rd_act;
    assign we_n   = ~(wr_act & ~rom_hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q         <= 1'b0;
            wp_violation <= 1'b0;
        end else begin
            wr_q         <= wr_act;
            wp_violation <= wr_act & ~wr_q & rom_hit;
        end
    end

    // R7: protected pair never sees a write enable
    assert_no_rom_write_R7: assert property (@(posedge clk) disable iff (rst)
        (!we_n) |-> (!rom_hit && mem_io && !wr_n));
    // R8: violation flag lasts a single cycle
    assert_wp_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        wp_violation |=> !wp_violation);
endmodule

// File: rtl/mem_bank_decode.sv
module mem_bank_decode
    import mbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_strobe,
    input  logic [ADDR_W-1:0] bus_ad,
    input  logic              hi_byte_en_n,
    input  logic              mem_io,
    input  logic              rd_n,
    input  logic              wr_n,
    output logic [WORD_W-1:0] word_addr,
    output logic [NUM_PAIRS-1:0] ce_even_n,
    output logic [NUM_PAIRS-1:0] ce_odd_n,
    output logic              oe_n,
    output logic              we_n,
    output logic              wp_violation
);
    bus_latch_t latched;
    logic       access;
    logic       rom_hit;

    mbd_addr_latch u_latch (
        .clk          (clk),
        .rst          (rst),
        .addr_strobe  (addr_strobe),
        .bus_ad       (bus_ad),
        .hi_byte_en_n (hi_byte_en_n),
        .latched      (latched)
    );

    mbd_pair_decode u_decode (
        .clk       (clk),
        .rst       (rst),
        .latched   (latched),
        .access    (access),
        .ce_even_n (ce_even_n),
        .ce_odd_n  (ce_odd_n),
        .word_addr (word_addr),
        .rom_hit   (rom_hit)
    );

    mbd_strobe_ctrl u_strobe (
        .clk          (clk),
        .rst          (rst),
        .mem_io       (mem_io),
        .rd_n         (rd_n),
        .wr_n         (wr_n),
        .rom_hit      (rom_hit),
        .access       (access),
        .oe_n         (oe_n),
        .we_n         (we_n),
        .wp_violation (wp_violation)
    );

    // R6: chips stay off without an active memory strobe
    assert_idle_off_R6: assert property (@(posedge clk) disable iff (rst)
        (!mem_io || (rd_n && wr_n)) |-> (&ce_even_n && &ce_odd_n));
endmodule

// File: tb/mem_bank_decode_bench.sv
module mem_bank_decode_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_strobe = 1'b0;
    logic [19:0] bus_ad = '0;
    logic        hi_byte_en_n = 1'b1;
    logic        mem_io = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [16:0] word_addr;
    logic [3:0]  ce_even_n;
    logic [3:0]  ce_odd_n;
    logic        oe_n;
    logic        we_n;
    logic        wp_violation;

    always #10 clk = ~clk;

    mem_bank_decode u_mem_bank_decode (
        .clk(clk), .rst(rst), .addr_strobe(addr_strobe), .bus_ad(bus_ad),
        .hi_byte_en_n(hi_byte_en_n), .mem_io(mem_io), .rd_n(rd_n), .wr_n(wr_n),
        .word_addr(word_addr), .ce_even_n(ce_even_n), .ce_odd_n(ce_odd_n),
        .oe_n(oe_n), .we_n(we_n), .wp_violation(wp_violation)
    );

    typedef struct {
        logic [16:0] word;
        logic [3:0]  ce_e;
        logic [3:0]  ce_o;
        logic        oe;
        logic        we;
        logic        wp;
        string       tag;
    } exp_t;

    exp_t q[$];
    event sample_ev;
    int   vectors = 0;
    int   miscompares = 0;
    logic finished = 1'b0;

    task automatic cmp(string tag, string fld, int act, int exp);
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, fld, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(sample_ev);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                vectors++;
                cmp(e.tag, "word_addr", int'(word_addr), int'(e.word));
                cmp(e.tag, "ce_even_n", int'(ce_even_n), int'(e.ce_e));
                cmp(e.tag, "ce_odd_n", int'(ce_odd_n), int'(e.ce_o));
                cmp(e.tag, "oe_n", int'(oe_n), int'(e.oe));
                cmp(e.tag, "we_n", int'(we_n), int'(e.we));
                cmp(e.tag, "wp_violation", int'(wp_violation), int'(e.wp));
            end
        end
    end

    function automatic exp_t model(logic [19:0] a, logic hi_n, logic mem,
                                   logic rd, logic wr, logic wp, string tag);
        exp_t e;
        logic act;
        logic [3:0] sel;
        act   = mem && (rd || wr);
        sel   = 4'b0001 << a[19:18];
        e.word = a[17:1];
        e.ce_e = ~((act && !a[0]) ? sel : 4'b0000);
        e.ce_o = ~((act && !hi_n) ? sel : 4'b0000);
        e.oe   = ~(mem && rd);
        e.we   = ~(mem && wr && (a[19:18] != 2'b11));
        e.wp   = wp;
        e.tag  = tag;
        return e;
    endfunction

    task automatic push_check(exp_t e);
        q.push_back(e);
        ->sample_ev;
        #1;
    endtask

    task automatic bus_cycle(logic [19:0] a, logic hi_n, logic mem, logic is_wr, string tag);
        exp_t e;
        @(negedge clk);
        addr_strobe = 1'b1; bus_ad = a; hi_byte_en_n = hi_n; mem_io = mem;
        @(negedge clk);
        addr_strobe = 1'b0;
        @(negedge clk);
        bus_ad = a ^ 20'hA5A5A;
        hi_byte_en_n = ~hi_n;
        if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
        #2;
        push_check(model(a, hi_n, mem, !is_wr, is_wr, 1'b0, {tag, " strobe"}));
        @(posedge clk); #2;
        e = model(a, hi_n, mem, !is_wr, is_wr,
                  is_wr && mem && (a[19:18] == 2'b11), {tag, " R8 edge"});
        push_check(e);
        @(posedge clk); #2;
        push_check(model(a, hi_n, mem, !is_wr, is_wr, 1'b0, {tag, " R8 after"}));
        @(negedge clk);
        rd_n = 1'b1; wr_n = 1'b1;
        #2;
        push_check(model(a, hi_n, mem, 1'b0, 1'b0, 1'b0, {tag, " R6 release"}));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        push_check(model(20'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R1 reset"));
        bus_cycle(20'h00000, 1'b0, 1'b1, 1'b0, "R5 word rd pair0");
        bus_cycle(20'h52468, 1'b1, 1'b1, 1'b0, "R5 even rd pair1 R3");
        bus_cycle(20'h9ABCD, 1'b0, 1'b1, 1'b0, "R5 odd rd pair2 R2");
        bus_cycle(20'h30001, 1'b1, 1'b1, 1'b0, "R5 idle lanes");
        bus_cycle(20'hFFFF0, 1'b0, 1'b1, 1'b0, "R4 rom rd pair3");
        bus_cycle(20'h81234, 1'b0, 1'b1, 1'b1, "R7 sram wr");
        bus_cycle(20'hC0002, 1'b0, 1'b1, 1'b1, "R8 rom wr");
        bus_cycle(20'h12344, 1'b0, 1'b0, 1'b0, "R6 io rd");
        bus_cycle(20'hE0010, 1'b0, 1'b0, 1'b1, "R6 io wr to rom");
        bus_cycle(20'h3FFFE, 1'b0, 1'b1, 1'b0, "R3 top of pair0");
        bus_cycle(20'h40000, 1'b0, 1'b1, 1'b1, "R4 base of pair1");
        bus_cycle(20'hFFFFF, 1'b0, 1'b1, 1'b1, "R5 rom odd wr");
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule